// File: doc/BRIEF.md
# Board Interrupt Aggregator and Control Registers

This block sits on a simple single-cycle register bus. It samples sixteen level-sensitive external interrupt lines into a one-cycle level record. For each line whose mask-enable bit is set, it latches a high level into a sticky pending register. It drives one registered parent interrupt, which is high while any pending bit is also enabled. Software clears or sets pending bits by writing the pending register directly.

Beside the interrupt logic the block holds seven general 32-bit control registers for LEDs, switches and miscellaneous controls. It also has one read-only word that returns an input port. Two socket status/control registers accept software writes only in their power/reset field. Their card-absent bit follows a dedicated interrupt line. An access to an unmapped offset returns zero, changes nothing, and raises a one-cycle error strobe.

Top module: `board_irq_ctrl`

## Requirements
- R1: After reset both socket registers read 0x0000_0420, which is bit 10 ready plus bit 5 card-absent. All other registers read zero, and `irq_out` and `bus_err` are low.
- R2: The plain registers at offsets 0x10, 0x14, 0x40, 0x60, 0x80, 0x84 and 0x88 store a full 32-bit write and return it on a read.
- R3: Offset 0x90 always reads the `misc_in` port, and a write to it changes nothing.
- R4: A write to the enable register (0xC0) or the pending register (0xD0) stores the data ANDed with 0x000F_EEFF, and a read returns the stored value.
- R5: Pending bit i becomes set when line i is high and enable bit i is set. A line driven high before clock edge k shows in the pending register after edge k+1. A line whose enable bit is clear never sets its pending bit.
- R6: A line going low never clears a pending bit. Only a write to 0xD0 can clear one.
- R7: `irq_out` is a register holding the OR-reduction of (pending AND enable). It changes on the clock edge after the edge that changed either register.
- R8: A write to socket 0 (0xE0) or socket 1 (0xE4) replaces only bits [4:0], and all higher bits keep their value.
- R9: Socket 0 bit 5 is the inverse of line 9, and socket 1 bit 5 is the inverse of line 13. Each shows after the second clock edge following the line change.
- R10: A read of an unmapped offset returns zero, and a write to one has no effect. `bus_err` is high for exactly the one cycle after any unmapped access and low after a mapped one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte offset of the register |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, combinational while a read is selected, else zero |
| bus_err | output | 1 | One-cycle strobe after an unmapped access |
| irq_lines | input | N_LINES | Level-sensitive external interrupt lines |
| misc_in | input | DW | Value returned by the read-only word |
| irq_out | output | 1 | Registered parent interrupt |

## Verification
The bench targets a few specific failure modes:
- Lines 8 and 12 sit under zero bits of the write mask. A design that skipped the mask would latch them.
- A line that is raised, then enabled, then dropped must leave its pending bit set. A design that tracked the level would lose the interrupt.
- The latency of `irq_out` is checked at a single cycle. A design that drove it combinationally, or registered it twice, would miss that cycle.
- The socket card-absent bits are exercised against software writes of all ones. A design that did not protect the upper bits would overwrite the ready and card-absent status.

// File: rtl/board_irq_pkg.sv
package board_irq_pkg;

   typedef enum logic [3:0] {
      RS_LED1   = 4'd0,
      RS_LED2   = 4'd1,
      RS_LEDCTL = 4'd2,
      RS_SWITCH = 4'd3,
      RS_MW1    = 4'd4,
      RS_MW2    = 4'd5,
      RS_MW3    = 4'd6,
      RS_MRD    = 4'd7,
      RS_MASK   = 4'd8,
      RS_PEND   = 4'd9,
      RS_SOCK0  = 4'd10,
      RS_SOCK1  = 4'd11,
      RS_NONE   = 4'd15
   } reg_sel_e;

   localparam int N_PLAIN = 7;
   localparam int N_SOCK  = 2;

   localparam logic [7:0] OFF_LED1   = 8'h10;
   localparam logic [7:0] OFF_LED2   = 8'h14;
   localparam logic [7:0] OFF_LEDCTL = 8'h40;
   localparam logic [7:0] OFF_SWITCH = 8'h60;
   localparam logic [7:0] OFF_MW1    = 8'h80;
   localparam logic [7:0] OFF_MW2    = 8'h84;
   localparam logic [7:0] OFF_MW3    = 8'h88;
   localparam logic [7:0] OFF_MRD    = 8'h90;
   localparam logic [7:0] OFF_MASK   = 8'hC0;
   localparam logic [7:0] OFF_PEND   = 8'hD0;
   localparam logic [7:0] OFF_SOCK0  = 8'hE0;
   localparam logic [7:0] OFF_SOCK1  = 8'hE4;

endpackage

// File: rtl/board_irq_decode.sv
module board_irq_decode
   import board_irq_pkg::*;
#(
   parameter int AW = 8
) (
   input  logic [AW-1:0] addr,
   output reg_sel_e      rsel
);

   logic upper_zero;
   assign upper_zero = ((addr >> 8) == '0);

   always_comb begin
      rsel = RS_NONE;
      if (upper_zero) begin
         case (addr[7:0])
            OFF_LED1:   rsel = RS_LED1;
            OFF_LED2:   rsel = RS_LED2;
            OFF_LEDCTL: rsel = RS_LEDCTL;
            OFF_SWITCH: rsel = RS_SWITCH;
            OFF_MW1:    rsel = RS_MW1;
            OFF_MW2:    rsel = RS_MW2;
            OFF_MW3:    rsel = RS_MW3;
            OFF_MRD:    rsel = RS_MRD;
            OFF_MASK:   rsel = RS_MASK;
            OFF_PEND:   rsel = RS_PEND;
            OFF_SOCK0:  rsel = RS_SOCK0;
            OFF_SOCK1:  rsel = RS_SOCK1;
            default:    rsel = RS_NONE;
         endcase
      end
   end

endmodule

// File: rtl/board_irq_pend.sv
module board_irq_pend #(
   parameter int             N_LINES = 16,
   parameter int             DW      = 32,
   parameter logic [DW-1:0]  WMASK   = 'h000F_EEFF
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_LINES-1:0] lines,
   input  logic               mask_we,
   input  logic               pend_we,
   input  logic [DW-1:0]      wdata,
   output logic [N_LINES-1:0] lvl_q,
   output logic [DW-1:0]      mask_q,
   output logic [DW-1:0]      pend_q,
   output logic               irq_q
);

   logic [DW-1:0] lvl_ext;
   logic [DW-1:0] pend_base;

   always_comb begin
      lvl_ext = '0;
      lvl_ext[N_LINES-1:0] = lvl_q;
   end

   assign pend_base = pend_we ? (wdata & WMASK) : pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q  <= '0;
         mask_q <= '0;
         pend_q <= '0;
         irq_q  <= 1'b0;
      end else begin
         lvl_q  <= lines;
         if (mask_we) mask_q <= wdata & WMASK;
         pend_q <= pend_base | (lvl_ext & mask_q & WMASK);
         irq_q  <= |(pend_q & mask_q);
      end
   end

endmodule

// File: rtl/board_irq_sock.sv
module board_irq_sock #(
   parameter int DW        = 32,
   parameter int WR_BITS   = 5,
   parameter int READY_BIT = 10,
   parameter int NCD_BIT   = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [DW-1:0] wdata,
   input  logic          cd_level,
   output logic [DW-1:0] q
);

   localparam logic [DW-1:0] RST_VAL = (DW'(1) << READY_BIT) | (DW'(1) << NCD_BIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= RST_VAL;
      end else begin
         if (we) q[WR_BITS-1:0] <= wdata[WR_BITS-1:0];
         q[NCD_BIT] <= ~cd_level;
      end
   end

endmodule

// File: rtl/board_irq_ctrl.sv
module board_irq_ctrl
   import board_irq_pkg::*;
#(
   parameter int             AW           = 8,
   parameter int             DW           = 32,
   parameter int             N_LINES      = 16,
   parameter logic [DW-1:0]  IRQ_WMASK    = 'h000F_EEFF,
   parameter int             CD0_LINE     = 9,
   parameter int             CD1_LINE     = 13,
   parameter int             SOCK_WR_BITS = 5,
   parameter int             READY_BIT    = 10,
   parameter int             NCD_BIT      = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_sel,
   input  logic               bus_wr,
   input  logic [AW-1:0]      bus_addr,
   input  logic [DW-1:0]      bus_wdata,
   output logic [DW-1:0]      bus_rdata,
   output logic               bus_err,
   input  logic [N_LINES-1:0] irq_lines,
   input  logic [DW-1:0]      misc_in,
   output logic               irq_out
);

   if (AW < 8) begin : g_bad_aw
      $error("board_irq_ctrl: AW must be at least 8");
   end
   if (N_LINES > DW) begin : g_bad_lines
      $error("board_irq_ctrl: N_LINES must not exceed DW");
   end
   if (CD0_LINE >= N_LINES || CD1_LINE >= N_LINES) begin : g_bad_cd
      $error("board_irq_ctrl: card-detect line out of range");
   end
   if (NCD_BIT < SOCK_WR_BITS || READY_BIT < SOCK_WR_BITS || READY_BIT >= DW || NCD_BIT >= DW) begin : g_bad_sock
      $error("board_irq_ctrl: socket status bits overlap the writable field");
   end

   reg_sel_e           rsel;
   logic               wr_en;
   logic [DW-1:0]      plain_q [N_PLAIN];
   logic [DW-1:0]      sock_q  [N_SOCK];
   logic [N_LINES-1:0] lvl_q;
   logic [DW-1:0]      mask_q;
   logic [DW-1:0]      pend_q;
   logic               err_q;

   assign wr_en = bus_sel && bus_wr;

   board_irq_decode #(.AW(AW)) u_dec (
      .addr (bus_addr),
      .rsel (rsel)
   );

   for (genvar g = 0; g < N_PLAIN; g++) begin : g_plain
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                   plain_q[g] <= '0;
         else if (wr_en && rsel == reg_sel_e'(4'(g)))  plain_q[g] <= bus_wdata;
      end
   end

   board_irq_pend #(
      .N_LINES (N_LINES),
      .DW      (DW),
      .WMASK   (IRQ_WMASK)
   ) u_pend (
      .clk     (clk),
      .rst_n   (rst_n),
      .lines   (irq_lines),
      .mask_we (wr_en && rsel == RS_MASK),
      .pend_we (wr_en && rsel == RS_PEND),
      .wdata   (bus_wdata),
      .lvl_q   (lvl_q),
      .mask_q  (mask_q),
      .pend_q  (pend_q),
      .irq_q   (irq_out)
   );

   for (genvar s = 0; s < N_SOCK; s++) begin : g_sock
      localparam int       CDL = (s == 0) ? CD0_LINE : CD1_LINE;
      localparam reg_sel_e SEL = (s == 0) ? RS_SOCK0 : RS_SOCK1;
      board_irq_sock #(
         .DW        (DW),
         .WR_BITS   (SOCK_WR_BITS),
         .READY_BIT (READY_BIT),
         .NCD_BIT   (NCD_BIT)
      ) u_sock (
         .clk      (clk),
         .rst_n    (rst_n),
         .we       (wr_en && rsel == SEL),
         .wdata    (bus_wdata),
         .cd_level (lvl_q[CDL]),
         .q        (sock_q[s])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) err_q <= 1'b0;
      else        err_q <= bus_sel && (rsel == RS_NONE);
   end
   assign bus_err = err_q;

   always_comb begin
      bus_rdata = '0;
      if (bus_sel && !bus_wr) begin
         case (rsel)
            RS_MRD:   bus_rdata = misc_in;
            RS_MASK:  bus_rdata = mask_q;
            RS_PEND:  bus_rdata = pend_q;
            RS_SOCK0: bus_rdata = sock_q[0];
            RS_SOCK1: bus_rdata = sock_q[1];
            default: begin
               for (int g = 0; g < N_PLAIN; g++)
                  if (rsel == reg_sel_e'(4'(g))) bus_rdata = plain_q[g];
            end
         endcase
      end
   end

endmodule

// File: rtl/board_irq_ctrl_chk.sv
module board_irq_ctrl_chk #(
   parameter int            AW       = 8,
   parameter int            DW       = 32,
   parameter int            N_LINES  = 16,
   parameter logic [DW-1:0] WMASK    = 'h000F_EEFF,
   parameter int            CD0_LINE = 9,
   parameter int            CD1_LINE = 13,
   parameter int            WR_BITS  = 5,
   parameter int            NCD_BIT  = 5
) (
   input logic               clk,
   input logic               rst_n,
   input logic               bus_sel,
   input logic               bus_wr,
   input logic [AW-1:0]      bus_addr,
   input logic               bus_err,
   input logic               irq_out,
   input logic [N_LINES-1:0] lvl_q,
   input logic [DW-1:0]      mask_q,
   input logic [DW-1:0]      pend_q,
   input logic [DW-1:0]      sock0_q,
   input logic [DW-1:0]      sock1_q
);

   function automatic logic mapped(input logic [AW-1:0] a);
      if ((a >> 8) != '0) return 1'b0;
      case (a[7:0])
         8'h10, 8'h14, 8'h40, 8'h60, 8'h80, 8'h84, 8'h88,
         8'h90, 8'hC0, 8'hD0, 8'hE0, 8'hE4: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   logic [DW-1:0] lvl_ext;
   logic          wr_pend, wr_s0, wr_s1;

   always_comb begin
      lvl_ext = '0;
      lvl_ext[N_LINES-1:0] = lvl_q;
   end
   assign wr_pend = bus_sel && bus_wr && (bus_addr == AW'(8'hD0));
   assign wr_s0   = bus_sel && bus_wr && (bus_addr == AW'(8'hE0));
   assign wr_s1   = bus_sel && bus_wr && (bus_addr == AW'(8'hE4));

   p_unmapped_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !mapped(bus_addr)) |=> bus_err);

   p_mapped_noerr_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && mapped(bus_addr)) |=> !bus_err);

   p_irq_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out == $past(|(pend_q & mask_q)));

   p_pend_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q & $past(lvl_ext & mask_q & WMASK)) == $past(lvl_ext & mask_q & WMASK));

   p_pend_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(wr_pend) |-> ((pend_q & $past(pend_q)) == $past(pend_q)));

   p_sock_upper_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(sock0_q[DW-1:NCD_BIT+1]) && $stable(sock1_q[DW-1:NCD_BIT+1]));

   p_sock0_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(wr_s0) |-> $stable(sock0_q[WR_BITS-1:0]));

   p_sock1_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(wr_s1) |-> $stable(sock1_q[WR_BITS-1:0]));

   p_cd0_r9: assert property (@(posedge clk) disable iff (!rst_n)
      sock0_q[NCD_BIT] == !$past(lvl_q[CD0_LINE]));

   p_cd1_r9: assert property (@(posedge clk) disable iff (!rst_n)
      sock1_q[NCD_BIT] == !$past(lvl_q[CD1_LINE]));

endmodule

bind board_irq_ctrl board_irq_ctrl_chk #(
   .AW       (AW),
   .DW       (DW),
   .N_LINES  (N_LINES),
   .WMASK    (IRQ_WMASK),
   .CD0_LINE (CD0_LINE),
   .CD1_LINE (CD1_LINE),
   .WR_BITS  (SOCK_WR_BITS),
   .NCD_BIT  (NCD_BIT)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_sel  (bus_sel),
   .bus_wr   (bus_wr),
   .bus_addr (bus_addr),
   .bus_err  (bus_err),
   .irq_out  (irq_out),
   .lvl_q    (lvl_q),
   .mask_q   (mask_q),
   .pend_q   (pend_q),
   .sock0_q  (sock_q[0]),
   .sock1_q  (sock_q[1])
);

// File: tb/board_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module board_irq_ctrl_tb_top;

   localparam logic [31:0] MISC_VAL = 32'hC0FFEE00;

   typedef struct packed {
      logic [7:0]  a;
      logic [31:0] wd;
      logic [31:0] exp;
      logic        err;
   } vec_t;

   localparam int NV = 15;
   localparam vec_t VECS [NV] = '{
      '{8'h10, 32'hDEADBEEF, 32'hDEADBEEF, 1'b0},  // R2
      '{8'h14, 32'h12345678, 32'h12345678, 1'b0},  // R2
      '{8'h40, 32'hA5A5A5A5, 32'hA5A5A5A5, 1'b0},  // R2
      '{8'h60, 32'h0000FFFF, 32'h0000FFFF, 1'b0},  // R2
      '{8'h80, 32'h11111111, 32'h11111111, 1'b0},  // R2
      '{8'h84, 32'h22222222, 32'h22222222, 1'b0},  // R2
      '{8'h88, 32'h33333333, 32'h33333333, 1'b0},  // R2
      '{8'h90, 32'hFFFFFFFF, MISC_VAL,     1'b0},  // R3
      '{8'hC0, 32'hFFFFFFFF, 32'h000FEEFF, 1'b0},  // R4
      '{8'hD0, 32'hFFFFFFFF, 32'h000FEEFF, 1'b0},  // R4
      '{8'hD0, 32'h00000000, 32'h00000000, 1'b0},  // R6
      '{8'hC0, 32'h00000000, 32'h00000000, 1'b0},  // R4
      '{8'hE0, 32'hFFFFFFFF, 32'h0000043F, 1'b0},  // R8
      '{8'hE4, 32'h0000000A, 32'h0000042A, 1'b0},  // R8
      '{8'h24, 32'hFFFFFFFF, 32'h00000000, 1'b1}   // R10
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        bus_err;
   logic [15:0] irq_lines = '0;
   logic [31:0] misc_in = MISC_VAL;
   logic        irq_out;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   board_irq_ctrl dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .bus_err   (bus_err),
      .irq_lines (irq_lines),
      .misc_in   (misc_in),
      .irq_out   (irq_out)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic do_write(input logic [7:0] a, input logic [31:0] d, output logic e);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
      e = bus_err;
   endtask

   task automatic do_read(input logic [7:0] a, output logic [31:0] d, output logic e);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_sel = 1'b0;
      e = bus_err;
   endtask

   task automatic wait_neg(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      logic [31:0] rd;
      logic        e;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // Reset state (R1)
      check("R1 irq_out", {31'd0, irq_out}, 32'd0);
      check("R1 bus_err", {31'd0, bus_err}, 32'd0);
      do_read(8'hE0, rd, e); check("R1 sock0", rd, 32'h00000420);
      do_read(8'hE4, rd, e); check("R1 sock1", rd, 32'h00000420);
      do_read(8'hC0, rd, e); check("R1 mask", rd, 32'd0);
      do_read(8'hD0, rd, e); check("R1 pend", rd, 32'd0);
      do_read(8'h10, rd, e); check("R1 led1", rd, 32'd0);

      // Vector table: write, read back, error strobe
      for (int i = 0; i < NV; i++) begin
         logic e_w;
         do_write(VECS[i].a, VECS[i].wd, e_w);
         do_read(VECS[i].a, rd, e);
         check($sformatf("R2/R3/R4/R8/R10 readback @%02h", VECS[i].a), rd, VECS[i].exp);
         check($sformatf("R10 err after write @%02h", VECS[i].a), {31'd0, e_w}, {31'd0, VECS[i].err});
      end
      do_read(8'h10, rd, e); check("R10 led1 untouched by unmapped write", rd, 32'hDEADBEEF);

      // R5: disabled line does not latch
      irq_lines[3] = 1'b1;
      wait_neg(4);
      do_read(8'hD0, rd, e); check("R5 masked line blocked", rd, 32'd0);
      check("R7 irq low while disabled", {31'd0, irq_out}, 32'd0);
      // R5: enabling a held line latches it
      do_write(8'hC0, 32'h8, e);
      wait_neg(3);
      do_read(8'hD0, rd, e); check("R5 latch after enable", rd, 32'h8);
      check("R7 irq high", {31'd0, irq_out}, 32'd1);
      // R6: line drop keeps pending
      irq_lines[3] = 1'b0;
      wait_neg(3);
      do_read(8'hD0, rd, e); check("R6 sticky after line low", rd, 32'h8);
      // R7: disabling drops irq one cycle later
      do_write(8'hC0, 32'h0, e);
      check("R7 irq still high on write cycle", {31'd0, irq_out}, 32'd1);
      @(negedge clk);
      check("R7 irq low after disable", {31'd0, irq_out}, 32'd0);
      do_read(8'hD0, rd, e); check("R6 pend kept after disable", rd, 32'h8);
      do_write(8'hD0, 32'h0, e);
      do_read(8'hD0, rd, e); check("R6 software clear", rd, 32'd0);

      // R4/R5: bit 8 masked off in enable register
      do_write(8'hC0, 32'hFFFFFFFF, e);
      irq_lines[8] = 1'b1; irq_lines[4] = 1'b1;
      wait_neg(3);
      do_read(8'hD0, rd, e); check("R4 line 8 cannot latch", rd, 32'h10);
      irq_lines = '0;
      wait_neg(2);
      do_write(8'hD0, 32'h0, e);
      wait_neg(2);
      check("R7 irq low after clear", {31'd0, irq_out}, 32'd0);

      // R7: exact latency on a software set
      do_write(8'hD0, 32'h1, e);
      check("R7 irq not yet high", {31'd0, irq_out}, 32'd0);
      @(negedge clk);
      check("R7 irq high one cycle later", {31'd0, irq_out}, 32'd1);
      do_write(8'hD0, 32'h0, e);

      // R9: card-detect follows lines 9 and 13 inverted
      irq_lines[9] = 1'b1;
      wait_neg(3);
      do_read(8'hE0, rd, e); check("R9 sock0 card present", rd, 32'h0000041F);
      do_read(8'hE4, rd, e); check("R9 sock1 unaffected by line 9", rd, 32'h0000042A);
      irq_lines[13] = 1'b1;
      wait_neg(3);
      do_read(8'hE4, rd, e); check("R9 sock1 card present", rd, 32'h0000040A);
      irq_lines = '0;
      wait_neg(3);
      do_read(8'hE0, rd, e); check("R9 sock0 card absent again", rd, 32'h0000043F);
      do_write(8'hE4, 32'hFFFFFFE0, e);
      do_read(8'hE4, rd, e); check("R8 upper bits protected", rd, 32'h00000420);

      // R10: unmapped read
      do_read(8'h24, rd, e);
      check("R10 unmapped read data", rd, 32'd0);
      check("R10 err pulse", {31'd0, e}, 32'd1);
      @(negedge clk);
      check("R10 err one cycle only", {31'd0, bus_err}, 32'd0);
      do_read(8'h90, rd, e); check("R3 misc read", rd, MISC_VAL);
      check("R10 no err on mapped read", {31'd0, e}, 32'd0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule